// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns twelve external interrupt pins, split into four groups of four, three, four and one pins, into four group interrupt requests. Each pin first passes through a two-flop synchronizer. The pins of a group are then merged into a single group signal. Each group raises its request on a programmable edge or level condition.

An 8-bit control register holds two 2-bit sensitivity codes and two polarity bits. Each sensitivity code is shared by a pair of groups. Each polarity bit inverts the meaning of the code for one group of its pair only. The register accepts writes only while a 2-bit CPU interrupt-level input is at its highest value (both bits 1). It can be read at any time.

An edge sets a per-group pending flag. The flag is cleared by a one-cycle acknowledge pulse for that group. In a level mode the request also follows the live level, so an acknowledge does not remove it while the level holds.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the register reads 00h. With all pins low, all four requests are asserted, because code 00 without inversion includes the low-level condition.
- R2: A write changes bits 7:2 only when `cpu_lvl` is 2'b11, and the new value is visible on `rd_data` one cycle later. A write at any other level leaves `rd_data` unchanged.
- R3: Bits 1:0 of `rd_data` always read 0, whatever data was written.
- R4: `rd_data` always shows the stored value, whatever the value of `cpu_lvl`.
- R5: Code 01 without inversion is rising-edge only. A rise of the group's OR signal sets the request, and a fall does not.
- R6: Code 10 without inversion is falling-edge only. The request is set when the group's AND signal falls, which happens when one pin of an all-high group goes low.
- R7: Code 11 is both edges, in either polarity. Both a fall of the AND signal and a rise of the OR signal set the request.
- R8: Code 00 is a level mode. Without inversion it is falling edge plus low level, where the AND signal is 0. With inversion it is rising edge plus high level, where the OR signal is 1. The request stays asserted through an acknowledge while the level holds.
- R9: Bit 5 inverts the code in bits 7:6 for group 2 only, and group 3 is never inverted. Bit 2 inverts the code in bits 4:3 for group 0 only, and group 1 is never inverted. With inversion, code 01 means falling edge only and code 10 means rising edge only.
- R10: An edge request stays asserted until a one-cycle pulse on that group's bit of `ack`. The pulse clears that group only.
- R11: An edge request appears on the third rising clock edge after the pin changes. A level request appears on the second.
- R12: A new rising edge needs the OR signal to go from 0 to 1, so raising a second pin of a group that already has a pin high does nothing. A new falling edge needs the AND signal to go from 1 to 0, so lowering a second pin of a group that already has a pin low does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| cpu_lvl | input | 2 | Current CPU interrupt level; writes are taken only at 2'b11 |
| rd_data | output | 8 | Stored register value |
| pins_g0 | input | 4 | Group 0 pins (code bits 4:3, inverted by bit 2) |
| pins_g1 | input | 3 | Group 1 pins (code bits 4:3, never inverted) |
| pins_g2 | input | 4 | Group 2 pins (code bits 7:6, inverted by bit 5) |
| pins_g3 | input | 1 | Group 3 pin (code bits 7:6, never inverted) |
| ack | input | 4 | One-cycle acknowledge, one bit per group |
| irq | output | 4 | Interrupt request, one bit per group |

## Verification
The hold check on each request assumes `ack` is a clean pulse from the clock domain. It also assumes that a request drops only after an acknowledge, or while its group's code is 00 now or was 00 one cycle earlier. The write checks assume `wr_data` and `cpu_lvl` are stable around the sampling edge. The stimulus drives every input at the falling clock edge and holds each acknowledge for exactly one cycle. It changes the configuration only while the pins are quiet, so no edge reaches a group while its code is changing.

// File: rtl/eis_pkg.sv
package eis_pkg;

    localparam int NGRP  = 4;
    localparam int REG_W = 8;
    localparam int LVL_W = 2;

    // stored configuration; reserved bits are not kept
    typedef struct packed {
        logic [1:0] sens_a;   // groups 2 and 3
        logic       pol_a;    // inverts group 2
        logic [1:0] sens_b;   // groups 0 and 1
        logic       pol_b;    // inverts group 0
    } cfg_t;

    typedef struct packed {
        logic lvl_hi;
        logic lvl_lo;
        logic rise;
        logic fall;
    } sense_t;

    function automatic sense_t decode_sense(input logic [1:0] code, input logic inv);
        sense_t s;
        s = '0;
        unique case (code)
            2'b00: begin
                s.lvl_lo = ~inv;
                s.fall   = ~inv;
                s.lvl_hi = inv;
                s.rise   = inv;
            end
            2'b01: begin
                s.rise = ~inv;
                s.fall = inv;
            end
            2'b10: begin
                s.fall = ~inv;
                s.rise = inv;
            end
            default: begin
                s.rise = 1'b1;
                s.fall = 1'b1;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eis_cfg_reg.sv
module eis_cfg_reg
    import eis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [LVL_W-1:0] cpu_lvl,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rd_data
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;
    logic   unlocked;

    always_comb begin
        st_d     = st_q;
        unlocked = &cpu_lvl;
        if (wr_en && unlocked) begin
            st_d.cfg.sens_a = wr_data[7:6];
            st_d.cfg.pol_a  = wr_data[5];
            st_d.cfg.sens_b = wr_data[4:3];
            st_d.cfg.pol_b  = wr_data[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign rd_data = {st_q.cfg, 2'b00};

endmodule

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] dly;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = pins;
        st_d.s2  = st_q.s1;
        st_d.dly = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.dly;

endmodule

// File: rtl/eis_group.sv
module eis_group
    import eis_pkg::*;
#(
    parameter int W          = 4,
    parameter bit CAN_INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [1:0]   code,
    input  logic         inv,
    input  logic         ack,
    output logic         irq
);

    typedef struct packed {
        logic pend;
    } state_t;

    state_t st_d, st_q;
    sense_t sense;
    logic   inv_eff;
    logic   any_now, all_now, any_old, all_old;
    logic   rise_ev, fall_ev, hit, lvl_on;

    generate
        if (CAN_INVERT) begin : g_inv
            assign inv_eff = inv;
        end else begin : g_noinv
            assign inv_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        sense   = decode_sense(code, inv_eff);
        any_now = |cur;
        all_now = &cur;
        any_old = |prev;
        all_old = &prev;
        rise_ev = any_now & ~any_old;
        fall_ev = all_old & ~all_now;
        hit     = (sense.rise & rise_ev) | (sense.fall & fall_ev);
        lvl_on  = (sense.lvl_hi & any_now) | (sense.lvl_lo & ~all_now);
        st_d    = st_q;
        if (hit)      st_d.pend = 1'b1;
        else if (ack) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend | lvl_on;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int G0_PINS = 4,
    parameter int G1_PINS = 3,
    parameter int G2_PINS = 4,
    parameter int G3_PINS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [LVL_W-1:0]   cpu_lvl,
    output logic [REG_W-1:0]   rd_data,
    input  logic [G0_PINS-1:0] pins_g0,
    input  logic [G1_PINS-1:0] pins_g1,
    input  logic [G2_PINS-1:0] pins_g2,
    input  logic [G3_PINS-1:0] pins_g3,
    input  logic [NGRP-1:0]    ack,
    output logic [NGRP-1:0]    irq
);

    localparam int TOTAL = G0_PINS + G1_PINS + G2_PINS + G3_PINS;
    localparam int GW  [NGRP] = '{G0_PINS, G1_PINS, G2_PINS, G3_PINS};
    localparam int OFS [NGRP] = '{0, G0_PINS, G0_PINS + G1_PINS,
                                  G0_PINS + G1_PINS + G2_PINS};

    cfg_t             cfg;
    logic [TOTAL-1:0] pins_all;

    assign pins_all = {pins_g3, pins_g2, pins_g1, pins_g0};

    eis_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cpu_lvl (cpu_lvl),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int W = GW[g];
        localparam int O = OFS[g];
        logic [W-1:0] cur, prev;
        logic [1:0]   code;
        logic         inv;

        // upper pair uses field A, lower pair field B; even group of each pair invertible
        assign code = (g >= 2) ? cfg.sens_a : cfg.sens_b;
        assign inv  = (g >= 2) ? cfg.pol_a  : cfg.pol_b;

        eis_sync #(.W(W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pins  (pins_all[O +: W]),
            .cur   (cur),
            .prev  (prev)
        );

        eis_group #(.W(W), .CAN_INVERT(g % 2 == 0)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur),
            .prev  (prev),
            .code  (code),
            .inv   (inv),
            .ack   (ack[g]),
            .irq   (irq[g])
        );
    end

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
    import eis_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [LVL_W-1:0] cpu_lvl,
    input logic [REG_W-1:0] rd_data,
    input logic [NGRP-1:0]  ack,
    input logic [NGRP-1:0]  irq
);

    // R1: register is clear while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_value: assert (rd_data == '0);
        end
    end

    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_lvl != 2'b11) |=> $stable(rd_data));

    a_r2_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_lvl == 2'b11) |=> (rd_data[7:2] == $past(wr_data[7:2])));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1:0] == 2'b00);

    for (genvar g = 0; g < NGRP; g++) begin : g_hold
        logic [1:0] code;
        assign code = (g >= 2) ? rd_data[7:6] : rd_data[4:3];
        // R10: a request only drops after an acknowledge or in level mode
        a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[g]) |-> ($past(ack[g]) || code == 2'b00 || $past(code) == 2'b00));
    end

endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cpu_lvl (cpu_lvl),
    .rd_data (rd_data),
    .ack     (ack),
    .irq     (irq)
);

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cpu_lvl = '0;
    logic [7:0] rd_data;
    logic [3:0] pins_g0 = '0;
    logic [2:0] pins_g1 = '0;
    logic [3:0] pins_g2 = '0;
    logic [0:0] pins_g3 = '0;
    logic [3:0] ack = '0;
    logic [3:0] irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_sense u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cpu_lvl(cpu_lvl), .rd_data(rd_data), .pins_g0(pins_g0),
        .pins_g1(pins_g1), .pins_g2(pins_g2), .pins_g3(pins_g3),
        .ack(ack), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] d, input logic [1:0] lvl);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; cpu_lvl = lvl;
        @(negedge clk);
        wr_en = 1'b0; cpu_lvl = 2'b00;
    endtask

    task automatic pulse_ack(input logic [3:0] m);
        @(negedge clk);
        ack = m;
        @(negedge clk);
        ack = '0;
    endtask

    task automatic set_pins(input logic [3:0] a, input logic [2:0] b,
                            input logic [3:0] c, input logic d);
        @(negedge clk);
        pins_g0 = a; pins_g1 = b; pins_g2 = c; pins_g3 = d;
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 reset register", rd_data, 8'h00);
        check("R1 low level after reset", {4'h0, irq}, 8'h0F);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(4);
        check("R1 pins high clears level", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_write_gate;
        write_reg(8'hFC, 2'b10);
        check("R2 locked write ignored", rd_data, 8'h00);
        write_reg(8'hFF, 2'b11);
        check("R3 reserved reads zero", rd_data, 8'hFC);
        write_reg(8'h00, 2'b01);
        check("R2 locked write keeps value", rd_data, 8'hFC);
        cpu_lvl = 2'b00;
        #1;
        check("R4 read at low level", rd_data, 8'hFC);
    endtask

    task automatic t_rise;
        write_reg(8'h48, 2'b11);
        set_pins(4'h0, 3'h0, 4'h0, 1'b0);
        wait_cyc(4);
        check("R5 fall ignored in rise mode", {4'h0, irq}, 8'h00);
        set_pins(4'b0100, 3'h0, 4'h0, 1'b0);
        wait_cyc(2);
        check("R11 edge not before third edge", {4'h0, irq}, 8'h00);
        wait_cyc(1);
        check("R5 R11 rise seen on third edge", {4'h0, irq}, 8'h01);
        pulse_ack(4'b0001);
        check("R10 ack clears group 0", {4'h0, irq}, 8'h00);
        set_pins(4'b0101, 3'h0, 4'h0, 1'b0);
        wait_cyc(4);
        check("R12 second pin rise no new edge", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_fall;
        write_reg(8'h90, 2'b11);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(4);
        check("R6 rise ignored in fall mode", {4'h0, irq}, 8'h00);
        set_pins(4'hF, 3'b110, 4'hF, 1'b1);
        wait_cyc(3);
        check("R6 fall of AND on group 1", {4'h0, irq}, 8'h02);
        wait_cyc(3);
        check("R10 request held without ack", {4'h0, irq}, 8'h02);
        pulse_ack(4'b0010);
        check("R10 ack clears group 1", {4'h0, irq}, 8'h00);
        set_pins(4'hF, 3'b100, 4'hF, 1'b1);
        wait_cyc(4);
        check("R12 second pin fall no new edge", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_both;
        write_reg(8'hD8, 2'b11);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(4);
        check("R7 quiet before edges", {4'h0, irq}, 8'h00);
        set_pins(4'hF, 3'h7, 4'hF, 1'b0);
        wait_cyc(3);
        check("R7 falling edge group 3", {4'h0, irq}, 8'h08);
        pulse_ack(4'b1000);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(3);
        check("R7 rising edge group 3", {4'h0, irq}, 8'h08);
        pulse_ack(4'b1000);
        check("R10 ack clears group 3", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_polarity;
        write_reg(8'h6C, 2'b11);
        set_pins(4'h0, 3'h0, 4'h0, 1'b0);
        wait_cyc(4);
        check("R9 inverted groups take fall", {4'h0, irq}, 8'h05);
        pulse_ack(4'hF);
        check("R10 ack all", {4'h0, irq}, 8'h00);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(4);
        check("R9 plain groups take rise", {4'h0, irq}, 8'h0A);
        pulse_ack(4'hF);
    endtask

    task automatic t_level;
        write_reg(8'h20, 2'b11);
        #1;
        check("R8 inverted code 00 high level", {4'h0, irq}, 8'h04);
        pulse_ack(4'b0100);
        check("R8 level survives ack", {4'h0, irq}, 8'h04);
        set_pins(4'b1101, 3'h7, 4'hF, 1'b1);
        wait_cyc(2);
        check("R8 R11 low level on second edge", {4'h0, irq}, 8'h05);
        wait_cyc(1);
        pulse_ack(4'b0001);
        check("R8 low level survives ack", {4'h0, irq}, 8'h05);
        set_pins(4'hF, 3'h7, 4'hF, 1'b1);
        wait_cyc(2);
        check("R8 low level released", {4'h0, irq}, 8'h04);
        set_pins(4'hF, 3'h7, 4'h0, 1'b1);
        wait_cyc(2);
        check("R8 high level released", {4'h0, irq}, 8'h00);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_write_gate();
        t_rise();
        t_fall();
        t_both();
        t_polarity();
        t_level();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

endmodule